// File: doc/BRIEF.md
# External Interrupt Acceptance Unit

This unit decides, at each instruction boundary, whether an external device's interrupt is taken. It has one enable bit and no priority levels. When the processor signals that an instruction is finishing, the device request is high and interrupts are enabled, the unit takes the interrupt. It saves the processor's current PC, captures the device's 16-bit cause information, clears the enable bit and sends the processor a PC load. The load target is a handler address built from the device's 8-bit type code. The device receives a single-cycle acknowledge.

The instruction decoder drives three command strobes. Two of them set and clear the enable bit. The third is a return from the handler: it reloads the PC from the saved copy and turns interrupts back on. All other state saving is left to handler software.

Top module: `irq_accept_unit`

## Requirements
- R1: During and after reset, with no activity: `intEnable`, `intAck` and `pcLoad` are 0, and `savedPc`, `intInfo` and `pcTarget` are all zero.
- R2: An interrupt is taken on a rising clock edge only when `instrEnd`, `intReq` and `intEnable` are all 1 before that edge. After that edge, `intAck` is 1 for exactly one cycle.
- R3: When an interrupt is taken, `savedPc` holds the value `pcCur` had in the taking cycle, and keeps it until the next take.
- R4: When an interrupt is taken, `intInfo` holds `srcInfo` in bits 15..0, with bits 31..16 zero.
- R5: In the cycle `intAck` is high, `pcLoad` is 1 and `pcTarget` is the handler address: `srcType` in bits 11..4 and zero in every other bit.
- R6: Taking an interrupt clears `intEnable` in the same cycle that `intAck` rises.
- R7: `cmdEnable` sets `intEnable` after the edge, and `cmdDisable` clears it.
- R8: `cmdReturn` makes `pcLoad` 1 for one cycle with `pcTarget` equal to `savedPc`, and sets `intEnable`.
- R9: Taking an interrupt outranks any command in the same cycle. `intEnable` ends at 0 and `pcTarget` is the handler address, not `savedPc`.
- R10: With `intEnable` 0 or `instrEnd` 0, a request is not taken: `intAck` stays 0 and `savedPc` and `intInfo` keep their values.
- R11: When `cmdEnable` and `cmdDisable` arrive together, disable wins and `intEnable` ends at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instrEnd | input | 1 | Current instruction completes this cycle |
| intReq | input | 1 | Interrupt request from device |
| srcInfo | input | 16 | Cause information from device |
| srcType | input | 8 | Device type code for the handler address |
| pcCur | input | 32 | PC the processor would continue from |
| cmdEnable | input | 1 | Set the enable bit |
| cmdDisable | input | 1 | Clear the enable bit |
| cmdReturn | input | 1 | Return from handler |
| intAck | output | 1 | One-cycle acknowledge to device |
| intEnable | output | 1 | Current enable bit |
| pcLoad | output | 1 | Processor must load `pcTarget` into its PC |
| pcTarget | output | 32 | Handler address or restored PC |
| savedPc | output | 32 | PC saved at the last take |
| intInfo | output | 32 | Zero-extended cause of the last take |

## Verification
The take path is driven with a set of PC, cause and type codes that includes an all-zero type, an all-ones type and alternating bit patterns. A misplaced or truncated type field, or an info field that is not zero-extended, therefore shows up as a wrong bit. Each take is followed by a return, so a restore that used a stale or wrong PC is caught. Separate tests hold one of the three gate inputs low at a time to show that each one matters. Other tests stack commands on top of a take, and enable on top of disable, to pin down the priority order.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

  parameter int PC_W   = 32;
  parameter int INFO_W = 16;
  parameter int TYPE_W = 8;
  parameter int VEC_LSB = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;   // interrupt taken this cycle
    logic restore;  // handler return this cycle
  } irqStrobes_t;

endpackage

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_accept_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrEnd,
  input  logic        intReq,
  input  logic        cmdEnable,
  input  logic        cmdDisable,
  input  logic        cmdReturn,
  output irqStrobes_t strobes,
  output logic        ieQ,
  output logic        ackQ
);

  logic acceptNow;
  logic ieNext;

  assign acceptNow = instrEnd & intReq & ieQ;

  always_comb begin
    strobes.accept  = acceptNow;
    strobes.restore = cmdReturn & ~acceptNow;
  end

  // priority: take > return > disable > enable
  always_comb begin
    ieNext = ieQ;
    if (acceptNow)       ieNext = 1'b0;
    else if (cmdReturn)  ieNext = 1'b1;
    else if (cmdDisable) ieNext = 1'b0;
    else if (cmdEnable)  ieNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ieQ  <= 1'b0;
      ackQ <= 1'b0;
    end else begin
      ieQ  <= ieNext;
      ackQ <= acceptNow;
    end
  end

  // R2: acknowledge lasts a single cycle
  assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    ackQ |=> !ackQ);

  // R2: acknowledge only follows a cycle with interrupts enabled
  assert_ack_needs_enable_R2: assert property (@(posedge clk) disable iff (!rstN)
    ackQ |-> $past(ieQ));

  // R6: enable is off while acknowledging
  assert_ie_cleared_R6: assert property (@(posedge clk) disable iff (!rstN)
    ackQ |-> !ieQ);

  // R11: simultaneous enable and disable with no take or return leaves it off
  assert_disable_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdEnable && cmdDisable && !cmdReturn && !acceptNow) |=> !ieQ);

endmodule

// File: rtl/irq_accept_dp.sv
module irq_accept_dp
  import irq_accept_pkg::*;
#(
  parameter int PcW   = PC_W,
  parameter int InfoW = INFO_W,
  parameter int TypeW = TYPE_W,
  parameter int VecLsb = VEC_LSB
) (
  input  logic              clk,
  input  logic              rstN,
  input  irqStrobes_t       strobes,
  input  logic [PcW-1:0]    pcCur,
  input  logic [InfoW-1:0]  srcInfo,
  input  logic [TypeW-1:0]  srcType,
  output logic              pcLoad,
  output logic [PcW-1:0]    pcTarget,
  output logic [PcW-1:0]    savedPc,
  output logic [PcW-1:0]    intInfo
);

  localparam int VecMsb = VecLsb + TypeW - 1;

  logic [PcW-1:0] handlerVec;
  logic [PcW-1:0] infoExt;

  // handler address: type code in its field, zeros elsewhere
  genvar gi;
  generate
    for (gi = 0; gi < PcW; gi++) begin : g_vec
      if (gi >= VecLsb && gi <= VecMsb) begin : g_field
        assign handlerVec[gi] = srcType[gi-VecLsb];
      end else begin : g_zero
        assign handlerVec[gi] = 1'b0;
      end
    end
  endgenerate

  assign infoExt = {{(PcW-InfoW){1'b0}}, srcInfo};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      savedPc  <= '0;
      intInfo  <= '0;
      pcTarget <= '0;
      pcLoad   <= 1'b0;
    end else begin
      pcLoad <= strobes.accept | strobes.restore;
      if (strobes.accept) begin
        savedPc  <= pcCur;
        intInfo  <= infoExt;
        pcTarget <= handlerVec;
      end else if (strobes.restore) begin
        pcTarget <= savedPc;
      end
    end
  end

  // R5: after a take the target has no bits outside the type field
  assert_vec_shape_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.accept) |-> (pcLoad && pcTarget[VecLsb-1:0] == '0
                               && pcTarget[PcW-1:VecMsb+1] == '0));

  // R8: return reloads the previously saved PC
  assert_return_restores_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.restore) |-> (pcLoad && pcTarget == $past(savedPc)));

  // R4: upper part of the cause word stays clear
  assert_info_zero_ext_R4: assert property (@(posedge clk) disable iff (!rstN)
    intInfo[PcW-1:InfoW] == '0);

  // R10: saved state changes only after a take
  assert_saved_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.accept) |-> ($stable(savedPc) && $stable(intInfo)));

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_accept_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrEnd,
  input  logic        intReq,
  input  logic [15:0] srcInfo,
  input  logic [7:0]  srcType,
  input  logic [31:0] pcCur,
  input  logic        cmdEnable,
  input  logic        cmdDisable,
  input  logic        cmdReturn,
  output logic        intAck,
  output logic        intEnable,
  output logic        pcLoad,
  output logic [31:0] pcTarget,
  output logic [31:0] savedPc,
  output logic [31:0] intInfo
);

  irqStrobes_t strobes;

  irq_accept_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .instrEnd   (instrEnd),
    .intReq     (intReq),
    .cmdEnable  (cmdEnable),
    .cmdDisable (cmdDisable),
    .cmdReturn  (cmdReturn),
    .strobes    (strobes),
    .ieQ        (intEnable),
    .ackQ       (intAck)
  );

  irq_accept_dp #(
    .PcW    (32),
    .InfoW  (16),
    .TypeW  (8),
    .VecLsb (VEC_LSB)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .pcCur    (pcCur),
    .srcInfo  (srcInfo),
    .srcType  (srcType),
    .pcLoad   (pcLoad),
    .pcTarget (pcTarget),
    .savedPc  (savedPc),
    .intInfo  (intInfo)
  );

endmodule

// File: tb/irq_accept_unit_tb.sv
`timescale 1ns/1ps
module irq_accept_unit_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        instrEnd, intReq, cmdEnable, cmdDisable, cmdReturn;
  logic [15:0] srcInfo;
  logic [7:0]  srcType;
  logic [31:0] pcCur;
  logic        intAck, intEnable, pcLoad;
  logic [31:0] pcTarget, savedPc, intInfo;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  irq_accept_unit u_dut (
    .clk(clk), .rstN(rstN), .instrEnd(instrEnd), .intReq(intReq),
    .srcInfo(srcInfo), .srcType(srcType), .pcCur(pcCur),
    .cmdEnable(cmdEnable), .cmdDisable(cmdDisable), .cmdReturn(cmdReturn),
    .intAck(intAck), .intEnable(intEnable), .pcLoad(pcLoad),
    .pcTarget(pcTarget), .savedPc(savedPc), .intInfo(intInfo)
  );

  // {pcCur, srcInfo, srcType, expected handler address}
  localparam int NVEC = 5;
  localparam logic [87:0] VECS [NVEC] = '{
    {32'h0000_1000, 16'h1234, 8'h01, 32'h0000_0010},
    {32'hDEAD_BEEC, 16'hFFFF, 8'hFF, 32'h0000_0FF0},
    {32'h8000_0004, 16'h0000, 8'h00, 32'h0000_0000},
    {32'h5555_5554, 16'hA5A5, 8'hAA, 32'h0000_0AA0},
    {32'h0001_0200, 16'h8001, 8'h55, 32'h0000_0550}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    instrEnd = 0; intReq = 0; cmdEnable = 0; cmdDisable = 0; cmdReturn = 0;
  endtask

  // inputs set by caller at negedge; wait for edge, settle
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic nextNeg();
    @(negedge clk); idle();
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 0; idle(); srcInfo = '0; srcType = '0; pcCur = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 intEnable", {31'b0, intEnable}, 32'd0);
    chk("R1 intAck", {31'b0, intAck}, 32'd0);
    chk("R1 pcLoad", {31'b0, pcLoad}, 32'd0);
    chk("R1 savedPc", savedPc, 32'd0);
    chk("R1 intInfo", intInfo, 32'd0);
    chk("R1 pcTarget", pcTarget, 32'd0);
    @(negedge clk); rstN = 1;

    // R10: disabled, request at boundary ignored
    nextNeg(); instrEnd = 1; intReq = 1; pcCur = 32'hCAFE_0000; srcInfo = 16'h7777; srcType = 8'h33;
    tick();
    chk("R10 ack when disabled", {31'b0, intAck}, 32'd0);
    chk("R10 savedPc when disabled", savedPc, 32'd0);
    chk("R10 intInfo when disabled", intInfo, 32'd0);

    // R7: enable
    nextNeg(); cmdEnable = 1; tick();
    chk("R7 enable", {31'b0, intEnable}, 32'd1);

    // R10: no boundary, request ignored
    nextNeg(); intReq = 1; instrEnd = 0; tick();
    chk("R10 ack without boundary", {31'b0, intAck}, 32'd0);
    chk("R10 savedPc without boundary", savedPc, 32'd0);

    // R10: boundary without request
    nextNeg(); instrEnd = 1; intReq = 0; tick();
    chk("R10 ack without request", {31'b0, intAck}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      nextNeg(); cmdEnable = 1; tick();
      nextNeg();
      pcCur = VECS[i][87:56]; srcInfo = VECS[i][55:40]; srcType = VECS[i][39:32];
      instrEnd = 1; intReq = 1;
      tick();
      chk("R2 ack", {31'b0, intAck}, 32'd1);
      chk("R5 pcLoad", {31'b0, pcLoad}, 32'd1);
      chk("R5 vector", pcTarget, VECS[i][31:0]);
      chk("R3 savedPc", savedPc, VECS[i][87:56]);
      chk("R4 intInfo", intInfo, {16'h0, VECS[i][55:40]});
      chk("R6 ie cleared", {31'b0, intEnable}, 32'd0);
      nextNeg(); pcCur = 32'h0BAD_0BAD; tick();
      chk("R2 ack drops", {31'b0, intAck}, 32'd0);
      chk("R3 savedPc held", savedPc, VECS[i][87:56]);
      nextNeg(); cmdReturn = 1; tick();
      chk("R8 pcLoad", {31'b0, pcLoad}, 32'd1);
      chk("R8 restored pc", pcTarget, VECS[i][87:56]);
      chk("R8 ie set", {31'b0, intEnable}, 32'd1);
      nextNeg(); tick();
      chk("R8 pcLoad one cycle", {31'b0, pcLoad}, 32'd0);
    end

    // R9: take with return and enable in the same cycle
    nextNeg(); pcCur = 32'h0000_4444; srcInfo = 16'h0042; srcType = 8'h9C;
    instrEnd = 1; intReq = 1; cmdReturn = 1; cmdEnable = 1;
    tick();
    chk("R9 ack", {31'b0, intAck}, 32'd1);
    chk("R9 ie off", {31'b0, intEnable}, 32'd0);
    chk("R9 target is vector", pcTarget, 32'h0000_09C0);
    chk("R9 savedPc", savedPc, 32'h0000_4444);

    // R11: enable and disable together
    nextNeg(); cmdEnable = 1; cmdDisable = 1; tick();
    chk("R11 disable wins", {31'b0, intEnable}, 32'd0);

    // R7: disable clears
    nextNeg(); cmdEnable = 1; tick();
    nextNeg(); cmdDisable = 1; tick();
    chk("R7 disable", {31'b0, intEnable}, 32'd0);

    // R10: no take after disable
    nextNeg(); instrEnd = 1; intReq = 1; pcCur = 32'h1111_1110; tick();
    chk("R10 ack after disable", {31'b0, intAck}, 32'd0);
    chk("R10 savedPc after disable", savedPc, 32'h0000_4444);

    nextNeg(); tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule